// File: doc/BRIEF.md
# Page Merge, Erase and Program Sequencer

This block runs the internal write cycle for one page of a flash-style array that can only be erased a whole page at a time. While the host is still sending data, a front end writes bytes into a page-sized staging buffer held inside the block. Each stored byte sets its bit in a supplied-byte mask. When the front end reports that chip select has returned high, it pulses `start` and gives the page number and the mode. The block then drives a simple synchronous array port until the page holds its new contents.

There are two modes. In rewrite mode (`startModePw` = 1) each byte can move to any value. The block reads the old page and fills every byte the host did not supply with its old value. It then erases the page, which leaves every byte at 0xFF, and programs all bytes of the page from the buffer. In clear-only mode (`startModePw` = 0) there is no erase. The block still reads the page, and for each supplied byte it writes old AND new, so bits can only go from 1 to 0. Bytes that were not supplied are left alone. `busy` covers the whole operation and `done` marks its last cycle.

Top module: `page_merge_seq`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `busy`, `done`, `arrRead`, `arrErase` and `arrWrite` are all 0.
- R2: A `start` seen while `busy` is 0 makes `busy` 1 in the next cycle. A `start` seen while `busy` is 1 has no effect: no second operation follows, and the page selected by the ignored request is never touched.
- R3: In rewrite mode, when the operation ends the page holds the new value in every supplied byte, including bits raised from 0 to 1, and its old value in every other byte.
- R4: In rewrite mode the block reads all bytes of the page first. It then issues exactly one `arrErase`, and after that one `arrWrite` for every byte in rising byte-index order. No read follows the erase or any write.
- R5: In clear-only mode there is no `arrErase`. There is exactly one `arrWrite` per supplied byte, in rising index order, with the value old AND new. Bytes that were not supplied keep their old value.
- R6: `done` is high for exactly one cycle. `busy` is low in the cycle after it. The time from `start` to `done` is fixed: rewrite mode takes PAGE_BYTES+2+ERASE_CYCLES+PAGE_BYTES*PROG_CYCLES cycles. Clear-only mode takes PAGE_BYTES+2 cycles, plus PROG_CYCLES for each supplied byte and 1 for each byte that was not supplied.
- R7: A `loadEn` while `busy` is 1 changes neither the buffer nor the mask. The mask is empty again after every operation, so a clear-only operation with no loads writes nothing.
- R8: `arrAddr` is {page, byte index}, with the byte index in the low log2(PAGE_BYTES) bits. The page field stays stable while busy, and no page other than the one latched at start is changed.
- R9: At most one of `arrRead`, `arrErase` and `arrWrite` is high in any cycle, and none is high while `busy` is 0.
- R10: `arrRdData` is taken one cycle after the `arrRead` that addressed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Chip select returned high: begin the write cycle |
| startModePw | input | 1 | Mode sampled with start: 1 rewrite, 0 clear-only |
| startPage | input | PAGE_AW | Page number sampled with start |
| loadEn | input | 1 | Store one byte into the staging buffer |
| loadIdx | input | log2(PAGE_BYTES) | Byte index within the page for the load |
| loadData | input | 8 | Byte value for the load |
| arrRead | output | 1 | Array read strobe |
| arrErase | output | 1 | Array page erase strobe |
| arrWrite | output | 1 | Array byte write strobe |
| arrAddr | output | PAGE_AW+log2(PAGE_BYTES) | Array address {page, byte index} |
| arrWrData | output | 8 | Byte to write |
| arrRdData | input | 8 | Read data, valid one cycle after arrRead |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |

## Verification
The hardest case to reach from the ports is a request that arrives while an operation is already running. A second `start` or a stray load only shows up in the result if it lands after the merge pass has already filled the byte in question. So the stimulus injects the intrusion a few cycles into the erase phase. For the stray load it targets a byte index that was not supplied. A bench model of the array then shows whether that byte or another page was changed. The emptiness of the mask after an operation is shown by a following clear-only operation that loads nothing and must produce no writes.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MERGE_READ,
    ST_ERASE,
    ST_PROGRAM,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture mode and page at start
    logic capture;  // fold array read data into buffer at capIdx
    logic clrMask;  // forget supplied-byte mask
  } seqStrobe_t;

endpackage

// File: rtl/pms_ctrl.sv
module pms_ctrl
  import pms_pkg::*;
#(
  parameter int PAGE_BYTES   = 256,
  parameter int ERASE_CYCLES = 16,
  parameter int PROG_CYCLES  = 2,
  localparam int IDXW = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            modePw,
  input  logic            curValid,
  output logic [IDXW-1:0] idx,
  output logic [IDXW-1:0] capIdx,
  output seqStrobe_t      strobe,
  output logic            arrRead,
  output logic            arrErase,
  output logic            arrWrite,
  output logic            busy,
  output logic            done
);

  localparam int MAXWAIT = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int WAITW   = $clog2(MAXWAIT + 1);
  localparam logic [WAITW-1:0] ERASE_LAST = WAITW'(ERASE_CYCLES - 1);
  localparam logic [WAITW-1:0] PROG_LAST  = WAITW'(PROG_CYCLES - 1);
  localparam logic [IDXW-1:0]  IDX_LAST   = IDXW'(PAGE_BYTES - 1);

  seqState_t       state;
  logic [WAITW-1:0] waitCnt;
  logic            readsDone;
  logic            pendValid;
  logic            doWrite;

  assign doWrite = modePw | curValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      capIdx    <= '0;
      waitCnt   <= '0;
      readsDone <= 1'b0;
      pendValid <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_MERGE_READ;
            idx       <= '0;
            readsDone <= 1'b0;
            pendValid <= 1'b0;
          end
        end
        ST_MERGE_READ: begin
          if (readsDone && pendValid) begin
            state     <= modePw ? ST_ERASE : ST_PROGRAM;
            idx       <= '0;
            waitCnt   <= '0;
            pendValid <= 1'b0;
          end else if (!readsDone) begin
            capIdx    <= idx;
            pendValid <= 1'b1;
            if (idx == IDX_LAST) readsDone <= 1'b1;
            else                 idx <= idx + 1'b1;
          end
        end
        ST_ERASE: begin
          if (waitCnt == ERASE_LAST) begin
            state   <= ST_PROGRAM;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_PROGRAM: begin
          if (!doWrite || waitCnt == PROG_LAST) begin
            waitCnt <= '0;
            if (idx == IDX_LAST) state <= ST_DONE;
            else                 idx <= idx + 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latch   = (state == ST_IDLE) && start;
    strobe.capture = (state == ST_MERGE_READ) && pendValid;
    strobe.clrMask = (state == ST_DONE);
    arrRead  = (state == ST_MERGE_READ) && !readsDone;
    arrErase = (state == ST_ERASE) && (waitCnt == '0);
    arrWrite = (state == ST_PROGRAM) && doWrite && (waitCnt == '0);
    busy     = (state != ST_IDLE);
    done     = (state == ST_DONE);
  end

endmodule

// File: rtl/pms_data.sv
module pms_data
  import pms_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int PAGE_AW    = 11,
  localparam int IDXW = $clog2(PAGE_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busy,
  input  logic               loadEn,
  input  logic [IDXW-1:0]    loadIdx,
  input  logic [7:0]         loadData,
  input  seqStrobe_t         strobe,
  input  logic               startModePw,
  input  logic [PAGE_AW-1:0] startPage,
  input  logic [IDXW-1:0]    idx,
  input  logic [IDXW-1:0]    capIdx,
  input  logic [7:0]         rdData,
  output logic               modePw,
  output logic [PAGE_AW-1:0] pageQ,
  output logic               curValid,
  output logic [7:0]         wrData
);

  logic [7:0]            bufMem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic                  hostLoad;

  assign hostLoad = loadEn && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMask <= '0;
      modePw    <= 1'b0;
      pageQ     <= '0;
    end else begin
      if (strobe.latch) begin
        modePw <= startModePw;
        pageQ  <= startPage;
      end
      if (strobe.clrMask)  validMask <= '0;
      else if (hostLoad)   validMask[loadIdx] <= 1'b1;
    end
  end

  // staging buffer: host loads before start, merge folds array data in
  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      if (modePw) begin
        if (!validMask[capIdx]) bufMem[capIdx] <= rdData;
      end else if (validMask[capIdx]) begin
        bufMem[capIdx] <= bufMem[capIdx] & rdData;
      end
    end else if (hostLoad) begin
      bufMem[loadIdx] <= loadData;
    end
  end

  assign curValid = validMask[idx];
  assign wrData   = bufMem[idx];

endmodule

// File: rtl/page_merge_seq.sv
module page_merge_seq
  import pms_pkg::*;
#(
  parameter int PAGE_BYTES   = 256,
  parameter int PAGE_AW      = 11,
  parameter int ERASE_CYCLES = 16,
  parameter int PROG_CYCLES  = 2,
  localparam int IDXW = $clog2(PAGE_BYTES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    startModePw,
  input  logic [PAGE_AW-1:0]      startPage,
  input  logic                    loadEn,
  input  logic [IDXW-1:0]         loadIdx,
  input  logic [7:0]              loadData,
  output logic                    arrRead,
  output logic                    arrErase,
  output logic                    arrWrite,
  output logic [PAGE_AW+IDXW-1:0] arrAddr,
  output logic [7:0]              arrWrData,
  input  logic [7:0]              arrRdData,
  output logic                    busy,
  output logic                    done
);

  seqStrobe_t         strobe;
  logic [IDXW-1:0]    idx;
  logic [IDXW-1:0]    capIdx;
  logic               modePw;
  logic               curValid;
  logic [PAGE_AW-1:0] pageQ;

  pms_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modePw(modePw), .curValid(curValid),
    .idx(idx), .capIdx(capIdx), .strobe(strobe),
    .arrRead(arrRead), .arrErase(arrErase), .arrWrite(arrWrite),
    .busy(busy), .done(done)
  );

  pms_data #(
    .PAGE_BYTES(PAGE_BYTES), .PAGE_AW(PAGE_AW)
  ) u_data (
    .clk(clk), .rstN(rstN), .busy(busy),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .strobe(strobe), .startModePw(startModePw), .startPage(startPage),
    .idx(idx), .capIdx(capIdx), .rdData(arrRdData),
    .modePw(modePw), .pageQ(pageQ), .curValid(curValid), .wrData(arrWrData)
  );

  assign arrAddr = {pageQ, idx};

endmodule

// File: rtl/page_merge_seq_chk.sv
module page_merge_seq_chk #(
  parameter int PAGE_AW = 11,
  parameter int IDXW    = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    arrRead,
  input logic                    arrErase,
  input logic                    arrWrite,
  input logic [PAGE_AW+IDXW-1:0] arrAddr
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> !busy && !done && !arrRead && !arrErase && !arrWrite);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  p_write_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    arrWrite |-> !$past(arrRead));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_busy_ends_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(done));

  p_page_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(arrAddr[PAGE_AW+IDXW-1:IDXW]));

  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrRead, arrErase, arrWrite}));

  p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (arrRead || arrErase || arrWrite) |-> busy);

endmodule

bind page_merge_seq page_merge_seq_chk #(.PAGE_AW(PAGE_AW), .IDXW(IDXW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .arrRead(arrRead), .arrErase(arrErase), .arrWrite(arrWrite), .arrAddr(arrAddr)
);

// File: tb/page_merge_seq_test.sv
module page_merge_seq_test;

  localparam int N      = 256;
  localparam int PAW    = 2;
  localparam int IW     = 8;
  localparam int ECYC   = 16;
  localparam int PCYC   = 2;
  localparam int MEMSZ  = N << PAW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic startModePw = 1'b0;
  logic [PAW-1:0] startPage = '0;
  logic loadEn = 1'b0;
  logic [IW-1:0] loadIdx = '0;
  logic [7:0] loadData = '0;
  logic arrRead, arrErase, arrWrite, busy, done;
  logic [PAW+IW-1:0] arrAddr;
  logic [7:0] arrWrData;
  logic [7:0] arrRdData;

  always #5 clk = ~clk;

  page_merge_seq #(
    .PAGE_BYTES(N), .PAGE_AW(PAW), .ERASE_CYCLES(ECYC), .PROG_CYCLES(PCYC)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start), .startModePw(startModePw),
    .startPage(startPage), .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .arrRead(arrRead), .arrErase(arrErase), .arrWrite(arrWrite), .arrAddr(arrAddr),
    .arrWrData(arrWrData), .arrRdData(arrRdData), .busy(busy), .done(done)
  );

  function automatic logic [7:0] initByte(int a);
    return 8'(((a * 7) + 13) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] newByte(int seed, int i);
    return 8'(seed ^ (i * 3));
  endfunction

  // array model
  logic [7:0] mem [MEMSZ];
  logic modelInit = 1'b1;
  logic cntClr = 1'b0;
  int eraseCnt, writeCnt, orderErr, multiErr;
  int lastWr;

  always @(posedge clk) begin
    if (modelInit) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= initByte(i);
      arrRdData <= '0;
      eraseCnt <= 0; writeCnt <= 0; orderErr <= 0; multiErr <= 0; lastWr <= -1;
    end else begin
      if (cntClr) begin
        eraseCnt <= 0; writeCnt <= 0; orderErr <= 0; multiErr <= 0; lastWr <= -1;
      end else begin
        if (32'(arrRead) + 32'(arrErase) + 32'(arrWrite) > 1) multiErr <= multiErr + 1;
        if ((arrRead || arrErase || arrWrite) && !busy) multiErr <= multiErr + 1;
        if (arrRead && (eraseCnt != 0 || writeCnt != 0)) orderErr <= orderErr + 1;
        if (arrErase) begin
          if (writeCnt != 0) orderErr <= orderErr + 1;
          eraseCnt <= eraseCnt + 1;
        end
        if (arrWrite) begin
          if (int'(arrAddr) <= lastWr) orderErr <= orderErr + 1;
          lastWr <= int'(arrAddr);
          writeCnt <= writeCnt + 1;
        end
      end
      if (arrRead) arrRdData <= mem[arrAddr];
      if (arrErase)
        for (int j = 0; j < N; j++) mem[{arrAddr[PAW+IW-1:IW], IW'(j)}] <= 8'hFF;
      if (arrWrite) mem[arrAddr] <= arrWrData;
    end
  end

  int total = 0;
  int bad = 0;
  bit timedOut = 1'b0;
  bit finished = 1'b0;
  logic [7:0] gold [MEMSZ];

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // mode, page, seed, first index, byte count
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{1, 0, 8'h11,  10,   5},
    '{1, 1, 8'h00,   0, 256},
    '{0, 2, 8'h3C, 100,  30},
    '{1, 2, 8'hA5, 255,   1},
    '{0, 0, 8'hF0,   0, 256},
    '{1, 3, 8'hFF,   0,   1},
    '{0, 3, 8'h0F,  50,  60}
  };

  task automatic runOp(int mode, int page, int seed, int first, int count, int intrude);
    logic [7:0] nb [N];
    bit sup [N];
    int cyc, expCyc, mism, badAddr, other;
    for (int i = 0; i < N; i++) begin sup[i] = 1'b0; nb[i] = '0; end
    for (int k = 0; k < count; k++) begin
      int i = first + k;
      nb[i] = newByte(seed, i);
      sup[i] = 1'b1;
      @(negedge clk);
      loadEn = 1'b1; loadIdx = IW'(i); loadData = nb[i];
    end
    @(negedge clk); loadEn = 1'b0; cntClr = 1'b1;
    @(negedge clk); cntClr = 1'b0;
    startModePw = mode[0]; startPage = PAW'(page); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    cyc = 1;
    while (!done && !timedOut) begin
      if (cyc == N + 5) begin
        if (intrude == 1) begin start = 1'b1; startPage = PAW'(page ^ 1); end
        if (intrude == 2) begin loadEn = 1'b1; loadIdx = 8'd7; loadData = 8'h00; end
      end
      @(negedge clk);
      start = 1'b0; loadEn = 1'b0;
      cyc++;
    end
    expCyc = N + 2;
    if (mode != 0) expCyc += ECYC + N * PCYC;
    else for (int i = 0; i < N; i++) expCyc += sup[i] ? PCYC : 1;
    check(cyc == expCyc, "R6 cycles start to done", cyc, expCyc);
    @(negedge clk);
    check(!done && !busy, "R6 done single pulse then idle", int'({done, busy}), 0);
    repeat (4) @(negedge clk);
    check(!busy, "R2 no restart after op", int'(busy), 0);
    // expected contents
    for (int i = 0; i < N; i++) begin
      int a = page * N + i;
      if (sup[i]) gold[a] = (mode != 0) ? nb[i] : (gold[a] & nb[i]);
    end
    mism = 0; other = 0; badAddr = -1;
    for (int a = 0; a < MEMSZ; a++)
      if (mem[a] !== gold[a]) begin
        if (a / N == page) mism++; else other++;
        if (badAddr < 0) badAddr = a;
      end
    if (mode != 0) check(mism == 0, "R3 R10 rewrite page contents", mism, 0);
    else           check(mism == 0, "R5 clear-only page contents", mism, 0);
    check(other == 0, "R8 other pages untouched", other, 0);
    if (badAddr >= 0) $display("  first mismatch at %0d: actual=%0d expected=%0d",
                               badAddr, mem[badAddr], gold[badAddr]);
    if (mode != 0) begin
      check(eraseCnt == 1, "R4 one erase", eraseCnt, 1);
      check(writeCnt == N, "R4 write count", writeCnt, N);
    end else begin
      check(eraseCnt == 0, "R5 no erase", eraseCnt, 0);
      check(writeCnt == count, "R5 R7 write count", writeCnt, count);
    end
    check(orderErr == 0, "R4 R5 operation order", orderErr, 0);
    check(multiErr == 0, "R9 strobe exclusivity", multiErr, 0);
  endtask

  initial begin
    for (int a = 0; a < MEMSZ; a++) gold[a] = initByte(a);
    repeat (3) @(negedge clk);
    check(!busy && !done && !arrRead && !arrErase && !arrWrite, "R1 state in reset",
          int'({busy, done, arrRead, arrErase, arrWrite}), 0);
    modelInit = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !arrRead && !arrErase && !arrWrite, "R1 state after reset",
          int'({busy, done, arrRead, arrErase, arrWrite}), 0);
    for (int v = 0; v < NV; v++)
      runOp(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 0);
    // R2: start during busy ignored
    runOp(1, 1, 8'h5A, 0, 3, 1);
    // R7: load during busy ignored (byte 7 not supplied)
    runOp(1, 0, 8'h66, 20, 4, 2);
    // R7: mask empty after an operation
    runOp(0, 0, 8'h00, 0, 0, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      timedOut = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule